// File: doc/BRIEF.md
# Programmable Asynchronous SRAM Access Sequencer

This block turns single-word requests from a synchronous client into read and write cycles on an asynchronous static RAM. The RAM has no clock. The sequencer drives its active-low chip select, output enable and write strobe. It also drives the address bus and the outgoing data bus with its enable, and it samples the incoming data bus. Every access moves through three phases: address setup, strobe and hold. The length of each phase is a whole number of controller clock cycles, so that the cycle can be fitted to the access, setup and hold times of the attached memory.

Reads and writes each have their own set of three phase-length fields. Each field holds the phase length minus one, so a field value of zero gives a one-cycle phase. The selected set is captured when the request is accepted, and any later change to the configuration inputs does not affect the access in flight. A read captures the data bus on the clock edge at which output enable returns high. The captured word appears on `rdata` together with a one-cycle `done` pulse that follows the hold phase.

Top module: `asram_seq`

## Requirements
- R1: While reset is held and after its release with no request, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, and `busy` and `done` are 0.
- R2: An access consists of a setup phase, then a strobe phase, then a hold phase. Chip select is low in all three phases. The strobe signal is low only in the strobe phase. The phases last field+1 cycles each.
- R3: A read takes its phase lengths from `rd_setup`/`rd_strobe`/`rd_hold`, and a write takes them from `wr_setup`/`wr_strobe`/`wr_hold`. The other set has no effect on the access.
- R4: During a read, `mem_oe_n` is low only in the strobe phase, and `mem_we_n` stays high for the whole access.
- R5: During a write, `mem_we_n` is low only in the strobe phase and `mem_oe_n` stays high. `mem_dout_en` is 1 and `mem_dout` equals the request data in every cycle in which `mem_ce_n` is low. `mem_dout_en` is 0 in all other cycles.
- R6: A read returns on `rdata` the word present on `mem_din` during the last strobe cycle. The word is valid while `done` is high and is held until the next read completes, so writes leave it unchanged.
- R7: `mem_addr` equals the request address and is stable in every cycle in which `mem_ce_n` is low.
- R8: A request is accepted only when `busy` is 0. A `req_valid` raised while `busy` is 1 starts no access.
- R9: `busy` rises on the cycle after acceptance. `done` is high for exactly one cycle, in the cycle right after the last hold cycle, with `busy` still 1. `busy` is 0 in the following cycle.
- R10: The timing fields are latched at acceptance. Changing them during an access does not change that access.
- R11: All-zero fields give a 3-cycle access. Fields of 15/63/15 give 16+64+16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_setup | input | 4 | Read setup length minus one |
| rd_strobe | input | 6 | Read strobe length minus one |
| rd_hold | input | 4 | Read hold length minus one |
| wr_setup | input | 4 | Write setup length minus one |
| wr_strobe | input | 6 | Write strobe length minus one |
| wr_hold | input | 4 | Write hold length minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read word |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dout | output | DATA_W | Outgoing data bus |
| mem_dout_en | output | 1 | Drive enable for the outgoing data bus |
| mem_din | input | DATA_W | Incoming data bus |

## Verification
The bench uses the default 16-bit address and data widths and the fixed 4/6/4-bit field widths. This puts both ends of every field within reach: zero fields give a three-cycle access, and saturated fields give a 96-cycle access. The memory model decodes the low eight address bits, which is enough for write-then-read-back checks. Mixing read and write field sets that differ from each other shows whether the wrong set is ever applied. Long setup phases leave room for a request pulse during `busy` and for configuration changes in the middle of an access.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 4;

    localparam int SH_MAX = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
    localparam int CNT_W  = (STROBE_W > SH_MAX) ? STROBE_W : SH_MAX;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } timing_t;

    function automatic logic phase_active(phase_e p);
        return (p == PH_SETUP) || (p == PH_STROBE) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/asram_timing_sel.sv
module asram_timing_sel
    import asram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                req_write,
    input  timing_t             rd_t,
    input  timing_t             wr_t,
    output logic [SETUP_W-1:0]  new_setup,
    output logic [STROBE_W-1:0] lat_strobe,
    output logic [HOLD_W-1:0]   lat_hold,
    output logic                wr_lat
);
    timing_t chosen;

    // Pick the set that matches the incoming request's direction.
    assign chosen    = req_write ? wr_t : rd_t;
    assign new_setup = chosen.setup;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_strobe <= '0;
            lat_hold   <= '0;
            wr_lat     <= 1'b0;
        end else if (accept) begin
            lat_strobe <= chosen.strobe;
            lat_hold   <= chosen.hold;
            wr_lat     <= req_write;
        end
    end
endmodule

// File: rtl/asram_phase_ctl.sv
module asram_phase_ctl
    import asram_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SETUP_W-1:0]  new_setup,
    input  logic [STROBE_W-1:0] lat_strobe,
    input  logic [HOLD_W-1:0]   lat_hold,
    output phase_e              phase_q,
    output phase_e              phase_n,
    output logic                accept,
    output logic                strobe_last
);
    logic [CNT_W-1:0] cnt_q, cnt_n;

    assign accept      = (phase_q == PH_IDLE) && req_valid;
    assign strobe_last = (phase_q == PH_STROBE) && (cnt_q == '0);

    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    phase_n = PH_SETUP;
                    cnt_n   = CNT_W'(new_setup);
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    phase_n = PH_STROBE;
                    cnt_n   = CNT_W'(lat_strobe);
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    phase_n = PH_HOLD;
                    cnt_n   = CNT_W'(lat_hold);
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    phase_n = PH_DONE;
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            PH_DONE: phase_n = PH_IDLE;
            default: phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
        end
    end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  phase_e            phase_n,
    input  logic              req_write,
    input  logic              wr_lat,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic wr_eff;
    logic act_n;
    logic strobe_n;

    assign wr_eff   = accept ? req_write : wr_lat;
    assign act_n    = phase_active(phase_n);
    assign strobe_n = (phase_n == PH_STROBE);

    // Pins come straight from flops that follow the next phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dout_en <= 1'b0;
            addr    <= '0;
            dout    <= '0;
        end else begin
            ce_n    <= !act_n;
            oe_n    <= !(strobe_n && !wr_eff);
            we_n    <= !(strobe_n && wr_eff);
            dout_en <= act_n && wr_eff;
            if (accept) begin
                addr <= req_addr;
                dout <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/asram_capture.sv
module asram_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grab,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)       rdata <= '0;
        else if (grab) rdata <= din;
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [SETUP_W-1:0]  rd_setup,
    input  logic [STROBE_W-1:0] rd_strobe,
    input  logic [HOLD_W-1:0]   rd_hold,
    input  logic [SETUP_W-1:0]  wr_setup,
    input  logic [STROBE_W-1:0] wr_strobe,
    input  logic [HOLD_W-1:0]   wr_hold,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dout,
    output logic                mem_dout_en,
    input  logic [DATA_W-1:0]   mem_din
);
    timing_t             rd_t, wr_t;
    logic [SETUP_W-1:0]  new_setup;
    logic [STROBE_W-1:0] lat_strobe;
    logic [HOLD_W-1:0]   lat_hold;
    logic                wr_lat;
    phase_e              phase_q, phase_n;
    logic                accept, strobe_last;

    assign rd_t = '{setup: rd_setup, strobe: rd_strobe, hold: rd_hold};
    assign wr_t = '{setup: wr_setup, strobe: wr_strobe, hold: wr_hold};

    asram_timing_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_write  (req_write),
        .rd_t       (rd_t),
        .wr_t       (wr_t),
        .new_setup  (new_setup),
        .lat_strobe (lat_strobe),
        .lat_hold   (lat_hold),
        .wr_lat     (wr_lat)
    );

    asram_phase_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .new_setup   (new_setup),
        .lat_strobe  (lat_strobe),
        .lat_hold    (lat_hold),
        .phase_q     (phase_q),
        .phase_n     (phase_n),
        .accept      (accept),
        .strobe_last (strobe_last)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .phase_n   (phase_n),
        .req_write (req_write),
        .wr_lat    (wr_lat),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .addr      (mem_addr),
        .dout      (mem_dout),
        .dout_en   (mem_dout_en)
    );

    asram_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .grab  (strobe_last && !wr_lat),
        .din   (mem_din),
        .rdata (rdata)
    );

    assign busy = (phase_q != PH_IDLE);
    assign done = (phase_q == PH_DONE);
endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    p_strobe_in_ce_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

    p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    p_dout_en_in_ce_r5: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> !mem_ce_n);

    p_dout_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_busy_from_req_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && mem_ce_n));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

bind asram_seq asram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/test_asram_seq.sv
module test_asram_seq;
    import asram_pkg::*;

    localparam int AW = 16;
    localparam int DW = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_write = 1'b0;
    logic [AW-1:0]       req_addr = '0;
    logic [DW-1:0]       req_wdata = '0;
    logic [SETUP_W-1:0]  rd_setup = '0, wr_setup = '0;
    logic [STROBE_W-1:0] rd_strobe = '0, wr_strobe = '0;
    logic [HOLD_W-1:0]   rd_hold = '0, wr_hold = '0;
    logic                busy, done;
    logic [DW-1:0]       rdata;
    logic                mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_dout, mem_din;

    always #2.5 clk = ~clk;

    asram_seq #(.ADDR_W(AW), .DATA_W(DW)) i_asram_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_setup(rd_setup), .rd_strobe(rd_strobe), .rd_hold(rd_hold),
        .wr_setup(wr_setup), .wr_strobe(wr_strobe), .wr_hold(wr_hold),
        .busy(busy), .done(done), .rdata(rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    // Memory model and bench reference copy
    logic [DW-1:0] sram    [256];
    logic [DW-1:0] ref_mem [256];
    assign mem_din = (!mem_ce_n && !mem_oe_n) ? sram[mem_addr[7:0]] : '0;

    typedef struct {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            su, st, ho;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int accesses = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: issue one access and push its expected outcome.
    task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int su, input int st, input int ho);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
        if (wr) begin
            wr_setup = SETUP_W'(su); wr_strobe = STROBE_W'(st); wr_hold = HOLD_W'(ho);
            rd_setup = SETUP_W'((su + 7) % 16); rd_strobe = STROBE_W'((st + 9) % 64);
            rd_hold = HOLD_W'((ho + 3) % 16);
        end else begin
            rd_setup = SETUP_W'(su); rd_strobe = STROBE_W'(st); rd_hold = HOLD_W'(ho);
            wr_setup = SETUP_W'((su + 5) % 16); wr_strobe = STROBE_W'((st + 11) % 64);
            wr_hold = HOLD_W'((ho + 6) % 16);
        end
        e.wr = wr; e.addr = a; e.su = su; e.st = st; e.ho = ho;
        if (wr) begin
            e.data = d;
            ref_mem[a[7:0]] = d;
        end else begin
            e.data = ref_mem[a[7:0]];
        end
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: measure phases and compare against the queue head.
    int su_c = 0, st_c = 0, ho_c = 0;
    bit seen_strobe = 1'b0;
    bit want_idle = 1'b0;
    bit prev_ce_n = 1'b1;
    bit extra_flag = 1'b0;
    logic [DW-1:0] last_rd = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n) begin
                if (exp_q.size() == 0) begin
                    if (!extra_flag) check(1'b0, "R8 access without accepted request", 1, 0);
                    extra_flag = 1'b1;
                end else begin
                    check(mem_addr == exp_q[0].addr, "R7 address", mem_addr, exp_q[0].addr);
                    check(mem_dout_en == exp_q[0].wr, "R5 dout_en in access", mem_dout_en, exp_q[0].wr);
                    if (exp_q[0].wr) begin
                        check(mem_dout == exp_q[0].data, "R5 write data", mem_dout, exp_q[0].data);
                        check(mem_oe_n, "R5 oe_n high on write", mem_oe_n, 1);
                    end else begin
                        check(mem_we_n, "R4 we_n high on read", mem_we_n, 1);
                    end
                    if (!mem_oe_n || !mem_we_n) begin
                        check(ho_c == 0, "R2 strobe after hold", ho_c, 0);
                        st_c++;
                        seen_strobe = 1'b1;
                    end else if (!seen_strobe) su_c++;
                    else ho_c++;
                    if (!mem_we_n) sram[mem_addr[7:0]] = mem_dout;
                end
            end else begin
                check(!mem_dout_en, "R5 dout_en outside access", mem_dout_en, 0);
            end

            if (done) begin
                check(busy, "R9 busy during done", busy, 1);
                check(!prev_ce_n, "R9 done right after hold", prev_ce_n, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 done without request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    accesses++;
                    check(su_c == e.su + 1, "R2 R3 setup length", su_c, e.su + 1);
                    check(st_c == e.st + 1, "R2 R3 strobe length", st_c, e.st + 1);
                    check(ho_c == e.ho + 1, "R2 R3 hold length", ho_c, e.ho + 1);
                    if (e.wr) begin
                        check(rdata == last_rd, "R6 rdata held over write", rdata, last_rd);
                    end else begin
                        check(rdata == e.data, "R6 read data", rdata, e.data);
                        last_rd = e.data;
                    end
                end
                su_c = 0; st_c = 0; ho_c = 0; seen_strobe = 1'b0;
                want_idle = 1'b1;
            end else if (want_idle) begin
                check(!busy, "R9 busy low after done", busy, 0);
                want_idle = 1'b0;
            end
            prev_ce_n = mem_ce_n;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i]    = DW'(16'hA500 + i * 3);
            ref_mem[i] = DW'(16'hA500 + i * 3);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dout_en && !busy && !done, "R1 flags low in reset",
              {mem_dout_en, busy, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle after reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dout_en && !busy && !done, "R1 flags low after reset",
              {mem_dout_en, busy, done}, 0);

        // Basic read and write with distinct field sets (R2 R3 R4 R5 R6 R7)
        do_access(1'b0, 16'h0010, '0, 2, 3, 1);
        do_access(1'b1, 16'h0020, 16'h1234, 1, 4, 2);
        do_access(1'b0, 16'h0020, '0, 3, 1, 4);
        do_access(1'b1, 16'h00FF, 16'hBEEF, 0, 2, 0);
        do_access(1'b0, 16'h00FF, '0, 1, 1, 1);

        // R11 minimum and maximum fields
        do_access(1'b0, 16'h0005, '0, 0, 0, 0);
        do_access(1'b1, 16'h0006, 16'h5A5A, 0, 0, 0);
        do_access(1'b0, 16'h0006, '0, 15, 63, 15);
        do_access(1'b1, 16'h0007, 16'hC3C3, 15, 63, 15);
        do_access(1'b0, 16'h0007, '0, 0, 0, 0);

        // R10 change fields mid access
        do_access(1'b0, 16'h0030, '0, 4, 5, 3);
        @(negedge clk);
        rd_setup = 4'd9; rd_strobe = 6'd20; rd_hold = 4'd12;
        wr_setup = 4'd1; wr_strobe = 6'd2; wr_hold = 4'd3;
        do_access(1'b1, 16'h0031, 16'h0F0F, 5, 2, 6);
        @(negedge clk);
        wr_setup = 4'd0; wr_strobe = 6'd40; wr_hold = 4'd0;

        // R8 request pulse while busy is ignored
        do_access(1'b0, 16'h0031, '0, 6, 2, 2);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0055; req_wdata = 16'hDEAD;
        repeat (3) @(negedge clk);
        check(busy, "R8 still busy during ignored pulse", busy, 1);
        req_valid = 1'b0;
        do_access(1'b0, 16'h0055, '0, 1, 2, 1);

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all requests completed", exp_q.size(), 0);
        check(accesses == 14, "R8 access count", accesses, 14);
        check(mem_ce_n && !busy, "R1 idle at end", {mem_ce_n, busy}, 2'b10);
        finish_run();
    end
endmodule